// File: doc/BRIEF.md
# Strided Gap-Skipping Block Copier

This block copies a byte count from a source region to a destination region. Each region is a series of lines separated by gaps. The source and the destination each have their own line length and gap length, both counted in 16-byte beats. The engine keeps one pointer per side. After every beat each pointer moves forward by 16 bytes. When a side's line runs out, that side's pointer also jumps over the side's gap, and the line count for that side reloads. The two sides do this independently of each other, so the source and destination may have different geometries.

A copy is requested with a one-cycle `start` pulse while the configuration inputs hold their values. The configuration is checked first. A request with a zero line length on either side, with fewer than 16 bytes to move, or with either base address outside the window `[VALID_LO, VALID_HI]` is refused: the block pulses `rejected` and moves nothing. An accepted copy issues one beat per cycle. Each beat presents `rd_addr` and takes `rd_data` from the read port in the same cycle. The beat is offered on a valid/ready write port. Back-pressure rules: while `wr_valid` is high and `wr_ready` is low, the beat is held with stable addresses and data, and no pointer or count moves. The beat is consumed in the cycle where both `wr_valid` and `wr_ready` are high. `wr_valid` never drops before its beat is taken.

Top module: `strided_copier`

## Requirements
- R1: If `start` arrives while idle and any of these holds, then one cycle later `rejected` is high for exactly one cycle and `busy` and `wr_valid` stay low: `src_line` is 0, `dst_line` is 0, `xfer_bytes` is below 16, or either base address lies outside `[VALID_LO, VALID_HI]`.
- R2: An accepted `start` raises `busy` and `wr_valid` in the next cycle. The first beat has `rd_addr = src_base` and `wr_addr = dst_base`.
- R3: In every beat, `wr_data` equals the `rd_data` returned for the `rd_addr` of that same cycle. `rd_en` is high exactly while the engine is busy.
- R4: After `src_line` accepted beats on a source line, the next source address is the last one plus 16 plus 16·`src_gap`. Inside a line, the next address is the last one plus 16.
- R5: The destination address follows the same rule using `dst_line` and `dst_gap`. Its line ends are independent of the source's line ends.
- R6: A copy moves exactly `xfer_bytes/16` beats; the low 4 bits are ignored. In the cycle after the last beat is accepted, `done` is high for one cycle and `busy` is low.
- R7: A `start` that arrives while busy is ignored. The running copy continues unchanged, and no second copy follows it.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `rd_addr` hold their values, and no position is lost.
- R9: After reset, `busy`, `done`, `rejected`, `wr_valid` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle copy request |
| src_base | input | ADDR_W | Source start byte address |
| dst_base | input | ADDR_W | Destination start byte address |
| src_line | input | LINE_W | Source line length in beats |
| src_gap | input | LINE_W | Source gap length in beats |
| dst_line | input | LINE_W | Destination line length in beats |
| dst_gap | input | LINE_W | Destination gap length in beats |
| xfer_bytes | input | SIZE_W | Total bytes to move (a multiple of 16) |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | One-cycle pulse for a refused request |
| rd_en | output | 1 | Read port enable |
| rd_addr | output | ADDR_W | Read port byte address |
| rd_data | input | DATA_W | Read port data, valid in the same cycle |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Write beat byte address |
| wr_data | output | DATA_W | Write beat data |

## Verification
The assertions check on every cycle the properties that hold locally: a stalled beat keeps its addresses, `done` lasts one cycle and always finds the engine idle, a refusal never comes with a beat, busy rises only after a request, and a side never steps with an empty line count. Only the bench's scenarios can show the address sequences. The bench compares every cycle against a behavioural model that uses a three-way minimum. It covers unequal source and destination geometries, a total that ends part-way through a line, each cause of refusal, a request made mid-copy, and sustained back-pressure.

// File: rtl/scopy_pkg.sv
package scopy_pkg;
  localparam int BEAT_BYTES = 16;
  localparam int BEAT_SHIFT = 4;
  localparam int NUM_LANES  = 2;
  localparam int LANE_SRC   = 0;
  localparam int LANE_DST   = 1;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_RUN  = 1'b1
  } copy_state_e;
endpackage

// File: rtl/scopy_cfg_check.sv
module scopy_cfg_check
  import scopy_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          LINE_W   = 8,
  parameter int          SIZE_W   = 20,
  parameter logic [31:0] VALID_LO = 32'h0000_1000,
  parameter logic [31:0] VALID_HI = 32'h0FFF_FFF0
) (
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LINE_W-1:0] src_line,
  input  logic [LINE_W-1:0] dst_line,
  input  logic [SIZE_W-1:0] xfer_bytes,
  output logic              cfg_ok
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(VALID_LO);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(VALID_HI);

  logic src_in_win, dst_in_win, lines_ok, size_ok;

  assign src_in_win = (src_base >= LO) && (src_base <= HI);
  assign dst_in_win = (dst_base >= LO) && (dst_base <= HI);
  assign lines_ok   = (src_line != '0) && (dst_line != '0);
  assign size_ok    = (xfer_bytes >= SIZE_W'(BEAT_BYTES));
  assign cfg_ok     = src_in_win && dst_in_win && lines_ok && size_ok;
endmodule

// File: rtl/scopy_lane_walker.sv
module scopy_lane_walker
  import scopy_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] gap,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(BEAT_BYTES);

  logic [LINE_W-1:0] line_q, gap_q, left_q;
  logic [ADDR_W-1:0] gap_bytes;
  logic              line_end;

  assign line_end  = (left_q == LINE_W'(1));
  assign gap_bytes = ADDR_W'(gap_q) << BEAT_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      line_q <= '0;
      gap_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      ptr    <= base;
      line_q <= line;
      gap_q  <= gap;
      left_q <= line;
    end else if (step) begin
      if (line_end) begin
        left_q <= line_q;
        ptr    <= ptr + STEP_BYTES + gap_bytes;
      end else begin
        left_q <= left_q - LINE_W'(1);
        ptr    <= ptr + STEP_BYTES;
      end
    end
  end

  // R4/R5: a side only steps while its current line still holds beats
  p_line_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (left_q != '0));
endmodule

// File: rtl/strided_copier.sv
module strided_copier
  import scopy_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 128,
  parameter int          LINE_W   = 8,
  parameter int          SIZE_W   = 20,
  parameter logic [31:0] VALID_LO = 32'h0000_1000,
  parameter logic [31:0] VALID_HI = 32'h0FFF_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LINE_W-1:0] src_line,
  input  logic [LINE_W-1:0] src_gap,
  input  logic [LINE_W-1:0] dst_line,
  input  logic [LINE_W-1:0] dst_gap,
  input  logic [SIZE_W-1:0] xfer_bytes,
  output logic              busy,
  output logic              done,
  output logic              rejected,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int BEATS_W = SIZE_W - BEAT_SHIFT;

  copy_state_e        st;
  logic [BEATS_W-1:0] beats_left;
  logic               cfg_ok, launch, step, last_beat;

  logic [ADDR_W-1:0] lane_base [NUM_LANES];
  logic [LINE_W-1:0] lane_line [NUM_LANES];
  logic [LINE_W-1:0] lane_gap  [NUM_LANES];
  logic [ADDR_W-1:0] lane_ptr  [NUM_LANES];

  scopy_cfg_check #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .SIZE_W(SIZE_W),
    .VALID_LO(VALID_LO), .VALID_HI(VALID_HI)
  ) u_check (
    .src_base  (src_base),
    .dst_base  (dst_base),
    .src_line  (src_line),
    .dst_line  (dst_line),
    .xfer_bytes(xfer_bytes),
    .cfg_ok    (cfg_ok)
  );

  assign lane_base[LANE_SRC] = src_base;
  assign lane_base[LANE_DST] = dst_base;
  assign lane_line[LANE_SRC] = src_line;
  assign lane_line[LANE_DST] = dst_line;
  assign lane_gap[LANE_SRC]  = src_gap;
  assign lane_gap[LANE_DST]  = dst_gap;

  assign launch    = (st == CS_IDLE) && start && cfg_ok;
  assign step      = (st == CS_RUN) && wr_ready;
  assign last_beat = (beats_left == BEATS_W'(1));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    scopy_lane_walker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_walk (
      .clk  (clk),
      .rst_n(rst_n),
      .load (launch),
      .step (step),
      .base (lane_base[g]),
      .line (lane_line[g]),
      .gap  (lane_gap[g]),
      .ptr  (lane_ptr[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= CS_IDLE;
      beats_left <= '0;
      done       <= 1'b0;
      rejected   <= 1'b0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      unique case (st)
        CS_IDLE: begin
          if (start) begin
            if (cfg_ok) begin
              st         <= CS_RUN;
              beats_left <= xfer_bytes[SIZE_W-1:BEAT_SHIFT];
            end else begin
              rejected <= 1'b1;
            end
          end
        end
        CS_RUN: begin
          if (step) begin
            if (last_beat) begin
              st         <= CS_IDLE;
              done       <= 1'b1;
              beats_left <= '0;
            end else begin
              beats_left <= beats_left - BEATS_W'(1);
            end
          end
        end
        default: st <= CS_IDLE;
      endcase
    end
  end

  assign busy     = (st == CS_RUN);
  assign rd_en    = busy;
  assign wr_valid = busy;
  assign rd_addr  = lane_ptr[LANE_SRC];
  assign wr_addr  = lane_ptr[LANE_DST];
  assign wr_data  = rd_data;

  // R8: a stalled beat keeps its addresses and stays offered
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(rd_addr)));
  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: completion finds the engine idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R1: a refusal never comes with a beat
  p_reject_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> (!wr_valid && !busy));
  // R2: busy rises only after a request
  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/strided_copier_bench.sv
`timescale 1ns/1ps
module strided_copier_bench;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 128;
  localparam int LINE_W = 8;
  localparam int SIZE_W = 20;
  localparam logic [31:0] LO = 32'h0000_1000;
  localparam logic [31:0] HI = 32'h0FFF_FFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] src_base = '0, dst_base = '0;
  logic [LINE_W-1:0] src_line = '0, src_gap = '0, dst_line = '0, dst_gap = '0;
  logic [SIZE_W-1:0] xfer_bytes = '0;
  logic busy, done, rejected, rd_en, wr_valid;
  logic wr_ready = 1'b0;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  always #2.5 clk = ~clk;

  function automatic logic [DATA_W-1:0] mem_word(input logic [31:0] a);
    return {a, ~a, a ^ 32'hA5A5_5A5A, a + 32'd1};
  endfunction
  assign rd_data = mem_word(rd_addr);

  strided_copier #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W),
                   .SIZE_W(SIZE_W), .VALID_LO(LO), .VALID_HI(HI)) u_strided_copier (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base),
    .src_line(src_line), .src_gap(src_gap), .dst_line(dst_line), .dst_gap(dst_gap),
    .xfer_bytes(xfer_bytes),
    .busy(busy), .done(done), .rejected(rejected),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state
  bit m_busy = 0, m_done = 0, m_rej = 0;
  logic [31:0] q_src[$];
  logic [31:0] q_dst[$];
  int m_accepted = 0;

  task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cycles, got, exp);
    end
  endtask

  function automatic bit cfg_good();
    return (src_line != 0) && (dst_line != 0) && (xfer_bytes >= 16) &&
           (src_base >= LO) && (src_base <= HI) && (dst_base >= LO) && (dst_base <= HI);
  endfunction

  // three-way minimum walk in byte terms
  task automatic build_expect();
    longint rem = longint'(xfer_bytes >> 4) * 16;
    longint iw = longint'(src_line) * 16;
    longint ow = longint'(dst_line) * 16;
    longint rin = iw, rout = ow;
    logic [31:0] s = src_base, d = dst_base;
    q_src.delete();
    q_dst.delete();
    while (rem > 0) begin
      longint c = rin;
      if (rout < c) c = rout;
      if (rem < c) c = rem;
      for (longint k = 0; k < c; k += 16) begin
        q_src.push_back(s + 32'(k));
        q_dst.push_back(d + 32'(k));
      end
      s += 32'(c); d += 32'(c);
      rin -= c; rout -= c; rem -= c;
      if (rin == 0) begin rin = iw; s += 32'(src_gap) * 32'd16; end
      if (rout == 0) begin rout = ow; d += 32'(dst_gap) * 32'd16; end
    end
  endtask

  // compare every cycle, then advance the model with the inputs seen now
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk("R2 busy", DATA_W'(busy), DATA_W'(m_busy));
      chk("R8 wr_valid", DATA_W'(wr_valid), DATA_W'(m_busy));
      chk("R3 rd_en", DATA_W'(rd_en), DATA_W'(m_busy));
      chk("R6 done", DATA_W'(done), DATA_W'(m_done));
      chk("R1 rejected", DATA_W'(rejected), DATA_W'(m_rej));
      if (m_busy && q_src.size() > 0) begin
        chk("R4 rd_addr", DATA_W'(rd_addr), DATA_W'(q_src[0]));
        chk("R5 wr_addr", DATA_W'(wr_addr), DATA_W'(q_dst[0]));
        chk("R3 wr_data", wr_data, mem_word(q_src[0]));
      end
      m_done = 0;
      m_rej = 0;
      if (m_busy) begin
        if (wr_ready) begin
          void'(q_src.pop_front());
          void'(q_dst.pop_front());
          m_accepted++;
          if (q_src.size() == 0) begin
            m_busy = 0;
            m_done = 1;
          end
        end
      end else if (start) begin
        if (cfg_good()) begin
          build_expect();
          m_busy = 1;
          m_accepted = 0;
        end else begin
          m_rej = 1;
        end
      end
      if (cycles > 100000) begin
        mismatched++;
        $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = lfsr[0];
      default: wr_ready = (lfsr[2:0] == 3'd0);
    endcase
  end

  task automatic request(input logic [31:0] sb, input logic [31:0] db,
                         input int sl, input int sg, input int dl, input int dg, input int nb);
    @(posedge clk); #1;
    src_base = sb; dst_base = db;
    src_line = LINE_W'(sl); src_gap = LINE_W'(sg);
    dst_line = LINE_W'(dl); dst_gap = LINE_W'(dg);
    xfer_bytes = SIZE_W'(nb);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state at the ports
    chk("R9 busy", DATA_W'(busy), '0);
    chk("R9 done", DATA_W'(done), '0);
    chk("R9 rejected", DATA_W'(rejected), '0);
    chk("R9 wr_valid", DATA_W'(wr_valid), '0);
    chk("R9 rd_en", DATA_W'(rd_en), '0);
    rst_n = 1'b1;

    // matched geometry, no back-pressure (R2 R3 R4 R5 R6)
    rdy_mode = 0;
    request(32'h0000_2000, 32'h0004_0000, 2, 1, 2, 1, 8 * 16);
    wait_idle();
    // unequal geometry under random back-pressure (R4 R5 R8)
    rdy_mode = 1;
    request(32'h0000_3000, 32'h0005_0000, 3, 2, 2, 0, 10 * 16);
    wait_idle();
    // total ends mid-line, low size bits ignored (R6)
    rdy_mode = 0;
    request(32'h0000_4000, 32'h0006_0000, 1, 0, 4, 3, 32'h57);
    wait_idle();
    chk("R6 beat count", DATA_W'(m_accepted), DATA_W'(5));

    // refusals (R1)
    request(32'h0000_2000, 32'h0004_0000, 0, 0, 2, 0, 64);
    wait_idle();
    request(32'h0000_2000, 32'h0004_0000, 2, 0, 0, 0, 64);
    wait_idle();
    request(32'h0000_2000, 32'h0004_0000, 2, 0, 2, 0, 8);
    wait_idle();
    request(32'h0000_0F00, 32'h0004_0000, 2, 0, 2, 0, 64);
    wait_idle();
    request(32'h0000_2000, 32'h1000_0000, 2, 0, 2, 0, 64);
    wait_idle();
    // boundary addresses are accepted (R1)
    request(LO, HI - 32'h100, 1, 1, 1, 1, 32);
    wait_idle();

    // R7: request during a copy is ignored
    rdy_mode = 2;
    request(32'h0000_5000, 32'h0007_0000, 2, 3, 3, 1, 6 * 16);
    repeat (4) @(posedge clk);
    #1;
    src_base = 32'h0000_9000; dst_line = 8'd1; xfer_bytes = SIZE_W'(20 * 16);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    wait_idle();
    chk("R7 beat count of first copy", DATA_W'(m_accepted), DATA_W'(6));
    chk("R7 idle after", DATA_W'(busy), '0);

    // long stalls on a wide copy (R8)
    rdy_mode = 2;
    request(32'h0000_6000, 32'h0008_0000, 4, 1, 5, 2, 23 * 16);
    wait_idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule